// File: doc/BRIEF.md
# Time-Bin Double Pulse Sequencer

This block produces the amplitude-channel sample stream for a converter that runs at 800 MS/s. Each 12.5 ns qubit slot is ten converter samples long and holds two pulses. The block works on a 200 MHz core clock, so every clock cycle it presents one word that holds four consecutive samples. A downstream ready input takes each word. While ready is low, the stream waits without losing its place.

The samples come from one of two sources. The first is a built-in double-pulse shape that the block computes when it is elaborated. The second is a pattern memory that is loaded through a simple write port and replayed from address 0 up to a programmable last address, after which it wraps. Ten samples per slot do not divide evenly into four samples per word. The built-in shape therefore repeats every five words, which is two slots. The block keeps a beat phase counter for this, and the counter runs in both source modes.

Top module: `dpulse_seq`

## Requirements
- R1: A slot is 10 samples long. Each output word carries 4 samples, with the earliest sample in bits [15:0] and later samples in the higher 16-bit lanes. The built-in pattern repeats every 5 accepted words.
- R2: The built-in slot shape is 0x7FFF at slot positions 0, 1, 4 and 5, and 0x0000 at positions 2, 3, 6, 7, 8 and 9. The two rising edges are therefore 4 samples apart.
- R3: When `src_fixed` is 1, the output shows the built-in pattern. When `src_fixed` is 0, it shows the pattern memory word at the read pointer. The select takes effect in the same cycle.
- R4: In memory mode, each 64-bit memory word is one output word, with the same lane packing as R1.
- R5: Each cycle in which `ready` is high at the clock edge, the read pointer steps by one. After it has presented `last_addr`, it returns to 0, so the replay period is `last_addr`+1 words. With `last_addr` = 0, address 0 repeats.
- R6: If `last_addr` is lowered below the current pointer, the next accepted word returns the pointer to 0.
- R7: While `ready` is low, the read pointer, the beat phase and the output word all hold their values.
- R8: A synchronous active-high `rst` returns the pointer and the beat phase to 0. The first word after reset is slot positions 0 to 3 of the built-in pattern, or memory word 0.
- R9: The beat phase advances on accepted words in both modes. After a source switch, the built-in pattern continues at the position given by the total number of words accepted since reset.
- R10: The memory holds 1024 words, written through `wr_en`/`wr_addr`/`wr_data`. Addresses up to 255 can be replayed. A write to an address that is not being read at that edge changes only that address, and the new content appears when the pointer reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz core clock |
| rst | input | 1 | Synchronous reset, active high |
| src_fixed | input | 1 | 1: built-in pattern, 0: pattern memory |
| last_addr | input | 8 | Highest memory address replayed before the wrap |
| ready | input | 1 | Downstream accepts the current word |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | 10 | Pattern memory write address |
| wr_data | input | 64 | Pattern memory write word |
| samples_o | output | 64 | Four 16-bit samples, earliest in the lowest lane |

## Verification
The hardest situation to reach is a last address lowered below a pointer that is already past it, combined with a source switch partway through a slot. The bench walks the pointer with ready held high until it stands at 7 under a limit of 9, then drops the limit to 3 and checks that the next word comes from address 0. It then toggles the source select and ready pseudo-randomly, so the built-in pattern reappears at every one of its five phases. Expected words come from an arithmetic model of the slot position, (phase*4+lane) mod 10, and from a bench copy of the loaded memory.

// File: rtl/dpulse_pkg.sv
package dpulse_pkg;

   function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
      return (a / gcd_u(a, b)) * b;
   endfunction

   // true when slot position pos falls inside one of the two pulses
   function automatic bit in_pulse(input int unsigned pos, input int unsigned pulse_w,
                                   input int unsigned edge_gap);
      return (pos < pulse_w) || ((pos >= edge_gap) && (pos < edge_gap + pulse_w));
   endfunction

endpackage

// File: rtl/dpulse_phase.sv
module dpulse_phase #(
   parameter int unsigned PERIOD_BEATS = 5,
   parameter int unsigned PH_W         = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   output logic [PH_W-1:0] phase
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_BEATS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
      end else if (adv) begin
         phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
      end
   end
endmodule

// File: rtl/dpulse_builtin.sv
module dpulse_builtin #(
   parameter int unsigned SAMPLE_W     = 16,
   parameter int unsigned LANES        = 4,
   parameter int unsigned SLOT_LEN     = 10,
   parameter int unsigned PULSE_W      = 2,
   parameter int unsigned EDGE_GAP     = 4,
   parameter int unsigned PERIOD_BEATS = 5,
   parameter int unsigned PH_W         = 3,
   parameter logic [SAMPLE_W-1:0] HI_CODE = 16'h7FFF,
   parameter logic [SAMPLE_W-1:0] LO_CODE = 16'h0000
) (
   input  logic [PH_W-1:0]           phase,
   output logic [SAMPLE_W*LANES-1:0] word
);
   localparam int unsigned MAP_N = 1 << PH_W;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [MAP_N-1:0] hi_map;
      for (genvar b = 0; b < MAP_N; b++) begin : g_beat
         localparam bit HI_B = (b < PERIOD_BEATS) &&
            dpulse_pkg::in_pulse((b * LANES + j) % SLOT_LEN, PULSE_W, EDGE_GAP);
         assign hi_map[b] = HI_B;
      end
      assign word[j*SAMPLE_W +: SAMPLE_W] = hi_map[phase] ? HI_CODE : LO_CODE;
   end
endmodule

// File: rtl/dpulse_ptr.sv
module dpulse_ptr #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LAST_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [LAST_W-1:0] last,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] ptr_nxt
);
   logic at_end;

   assign at_end = (ptr >= ADDR_W'(last));

   always_comb begin
      if (rst) begin
         ptr_nxt = '0;
      end else if (adv) begin
         ptr_nxt = at_end ? '0 : ptr + ADDR_W'(1);
      end else begin
         ptr_nxt = ptr;
      end
   end

   always_ff @(posedge clk) begin
      ptr <= ptr_nxt;
   end
endmodule

// File: rtl/dpulse_mem.sv
module dpulse_mem #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[waddr] <= wdata;
      end
      rdata <= store[raddr];
   end
endmodule

// File: rtl/dpulse_seq.sv
module dpulse_seq #(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned LANES     = 4,
   parameter int unsigned SLOT_LEN  = 10,
   parameter int unsigned PULSE_W   = 2,
   parameter int unsigned EDGE_GAP  = 4,
   parameter int unsigned MEM_DEPTH = 1024,
   parameter int unsigned LAST_W    = 8,
   parameter logic [SAMPLE_W-1:0] HI_CODE = 16'h7FFF,
   parameter logic [SAMPLE_W-1:0] LO_CODE = 16'h0000
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        src_fixed,
   input  logic [LAST_W-1:0]           last_addr,
   input  logic                        ready,
   input  logic                        wr_en,
   input  logic [$clog2(MEM_DEPTH)-1:0] wr_addr,
   input  logic [SAMPLE_W*LANES-1:0]   wr_data,
   output logic [SAMPLE_W*LANES-1:0]   samples_o
);
   localparam int unsigned WORD_W       = SAMPLE_W * LANES;
   localparam int unsigned ADDR_W       = $clog2(MEM_DEPTH);
   localparam int unsigned PERIOD_BEATS = dpulse_pkg::lcm_u(SLOT_LEN, LANES) / LANES;
   localparam int unsigned PH_W         = (PERIOD_BEATS > 1) ? $clog2(PERIOD_BEATS) : 1;

   // elaboration-time parameter checks
   if (EDGE_GAP <= PULSE_W) begin : g_chk_gap
      $error("dpulse_seq: EDGE_GAP must exceed PULSE_W");
   end
   if (EDGE_GAP + PULSE_W > SLOT_LEN) begin : g_chk_slot
      $error("dpulse_seq: second pulse does not fit in the slot");
   end
   if (LAST_W > ADDR_W) begin : g_chk_last
      $error("dpulse_seq: LAST_W wider than memory address");
   end
   if ((1 << ADDR_W) != MEM_DEPTH) begin : g_chk_depth
      $error("dpulse_seq: MEM_DEPTH must be a power of two");
   end

   logic [PH_W-1:0]   phase;
   logic [ADDR_W-1:0] rd_ptr;
   logic [ADDR_W-1:0] rd_ptr_nxt;
   logic [WORD_W-1:0] fixed_word;
   logic [WORD_W-1:0] mem_word;

   if (PERIOD_BEATS > 1) begin : g_phase_cnt
      dpulse_phase #(
         .PERIOD_BEATS(PERIOD_BEATS),
         .PH_W        (PH_W)
      ) u_phase (
         .clk  (clk),
         .rst  (rst),
         .adv  (ready),
         .phase(phase)
      );
   end else begin : g_phase_tied
      assign phase = '0;
   end

   dpulse_builtin #(
      .SAMPLE_W    (SAMPLE_W),
      .LANES       (LANES),
      .SLOT_LEN    (SLOT_LEN),
      .PULSE_W     (PULSE_W),
      .EDGE_GAP    (EDGE_GAP),
      .PERIOD_BEATS(PERIOD_BEATS),
      .PH_W        (PH_W),
      .HI_CODE     (HI_CODE),
      .LO_CODE     (LO_CODE)
   ) u_builtin (
      .phase(phase),
      .word (fixed_word)
   );

   dpulse_ptr #(
      .ADDR_W(ADDR_W),
      .LAST_W(LAST_W)
   ) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .adv    (ready),
      .last   (last_addr),
      .ptr    (rd_ptr),
      .ptr_nxt(rd_ptr_nxt)
   );

   dpulse_mem #(
      .DEPTH (MEM_DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(WORD_W)
   ) u_mem (
      .clk  (clk),
      .we   (wr_en),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_ptr_nxt),
      .rdata(mem_word)
   );

   assign samples_o = src_fixed ? fixed_word : mem_word;
endmodule

// File: rtl/dpulse_seq_chk.sv
module dpulse_seq_chk #(
   parameter int unsigned ADDR_W       = 10,
   parameter int unsigned LAST_W       = 8,
   parameter int unsigned PH_W         = 3,
   parameter int unsigned PERIOD_BEATS = 5,
   parameter int unsigned WORD_W       = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              ready,
   input logic              src_fixed,
   input logic [LAST_W-1:0] last_addr,
   input logic [ADDR_W-1:0] ptr,
   input logic [PH_W-1:0]   phase,
   input logic [WORD_W-1:0] samples
);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_BEATS - 1);

   AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ptr == '0) && (phase == '0)); // R8

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
      (ready && (ptr < ADDR_W'(last_addr))) |=> (ptr == $past(ptr) + ADDR_W'(1))); // R5

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
      (ready && (ptr >= ADDR_W'(last_addr))) |=> (ptr == '0)); // R6

   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ready |=> ($stable(ptr) && $stable(phase))); // R7

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      ready |=> (phase == (($past(phase) == PH_LAST) ? '0 : $past(phase) + PH_W'(1)))); // R9

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
      phase <= PH_LAST); // R1

   AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (src_fixed && !ready) |=> (!src_fixed || $stable(samples))); // R7
endmodule

bind dpulse_seq dpulse_seq_chk #(
   .ADDR_W      (ADDR_W),
   .LAST_W      (LAST_W),
   .PH_W        (PH_W),
   .PERIOD_BEATS(PERIOD_BEATS),
   .WORD_W      (WORD_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ready    (ready),
   .src_fixed(src_fixed),
   .last_addr(last_addr),
   .ptr      (rd_ptr),
   .phase    (phase),
   .samples  (samples_o)
);

// File: tb/tb_dpulse_seq.sv
`timescale 1ns/1ps
module tb_dpulse_seq;
   localparam int DEPTH = 1024;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        src_fixed = 1'b1;
   logic [7:0]  last_addr = 8'd4;
   logic        ready = 1'b0;
   logic        wr_en = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] samples_o;

   int total = 0;
   int bad = 0;
   int m_ptr = 0;
   int m_ph = 0;
   logic [63:0] mem_m [DEPTH];
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   dpulse_seq dut (
      .clk(clk), .rst(rst), .src_fixed(src_fixed), .last_addr(last_addr),
      .ready(ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .samples_o(samples_o)
   );

   function automatic logic [63:0] mem_word(input int a);
      return {16'(a * 7 + 3), 16'(a * 5 + 1) ^ 16'h5A5A, 16'(a + 1000), ~16'(a)};
   endfunction

   function automatic logic [63:0] fixed_word(input int ph);
      logic [63:0] w;
      for (int j = 0; j < 4; j++) begin
         int pos;
         pos = (ph * 4 + j) % 10;
         w[j*16 +: 16] = ((pos < 2) || (pos >= 4 && pos < 6)) ? 16'h7FFF : 16'h0000;
      end
      return w;
   endfunction

   function automatic logic next_rand(inout logic [15:0] s);
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      return s[0];
   endfunction

   // called at a falling edge: checks the current word, then applies r for the next edge
   task automatic cyc(input logic r, input string tag);
      logic [63:0] exp;
      #1;
      exp = src_fixed ? fixed_word(m_ph) : mem_m[m_ptr];
      total++;
      if (samples_o !== exp) begin
         bad++;
         $display("FAIL %s: samples_o=%h expected=%h (ptr=%0d phase=%0d)",
                  tag, samples_o, exp, m_ptr, m_ph);
      end
      ready = r;
      if (r) begin
         m_ph = (m_ph + 1) % 5;
         m_ptr = (m_ptr >= int'(last_addr)) ? 0 : m_ptr + 1;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_ptr = 0;
      m_ph = 0;
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R10: load the whole memory while reset is held
      for (int a = 0; a < DEPTH; a++) begin
         wr_en = 1'b1;
         wr_addr = 10'(a);
         wr_data = mem_word(a);
         mem_m[a] = mem_word(a);
         @(negedge clk);
      end
      wr_en = 1'b0;
      do_reset();

      // R8: first word after reset is slot positions 0..3
      cyc(1'b1, "R8");
      // R1/R2: built-in pattern with ready held high across several periods
      for (int i = 0; i < 10; i++) cyc(1'b1, "R1");
      for (int i = 0; i < 10; i++) cyc(1'b1, "R2");
      // R7: gaps in ready
      for (int i = 0; i < 30; i++) cyc(next_rand(lfsr), "R7");

      // R4/R5: memory replay for several last addresses
      src_fixed = 1'b0;
      last_addr = 8'd0;
      for (int i = 0; i < 6; i++) cyc(1'b1, "R5");
      last_addr = 8'd1;
      for (int i = 0; i < 10; i++) cyc(next_rand(lfsr), "R5");
      last_addr = 8'd2;
      for (int i = 0; i < 12; i++) cyc(1'b1, "R4");
      last_addr = 8'd5;
      for (int i = 0; i < 24; i++) cyc(next_rand(lfsr), "R4");
      last_addr = 8'd255;
      for (int i = 0; i < 520; i++) cyc(1'b1, "R10");

      // R6: lower the limit below the pointer
      last_addr = 8'd9;
      while (m_ptr != 7) cyc(1'b1, "R5");
      last_addr = 8'd3;
      cyc(1'b1, "R6");
      cyc(1'b1, "R6");
      for (int i = 0; i < 6; i++) cyc(1'b1, "R6");

      // R3: same state, both sources
      src_fixed = 1'b1;
      cyc(1'b0, "R3");
      src_fixed = 1'b0;
      cyc(1'b0, "R3");

      // R9: random source switching with random ready
      for (int i = 0; i < 60; i++) begin
         src_fixed = next_rand(lfsr);
         cyc(next_rand(lfsr), "R9");
      end

      // R10: rewrite an address that is not being read, then replay it
      src_fixed = 1'b0;
      last_addr = 8'd3;
      cyc(1'b0, "R10");
      begin
         int wa;
         wa = (m_ptr + 2) % 4;
         wr_en = 1'b1;
         wr_addr = 10'(wa);
         wr_data = ~mem_word(wa);
         cyc(1'b0, "R10");
         wr_en = 1'b0;
         mem_m[wa] = ~mem_word(wa);
      end
      for (int i = 0; i < 12; i++) cyc(1'b1, "R10");

      // R8: reset in the middle of a run, memory source
      do_reset();
      cyc(1'b1, "R8");
      for (int i = 0; i < 5; i++) cyc(1'b1, "R4");
      src_fixed = 1'b1;
      do_reset();
      cyc(1'b1, "R8");
      for (int i = 0; i < 7; i++) cyc(1'b1, "R1");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule